// File: doc/BRIEF.md
# Bus-Mapped Multi-Function Timer with Watchdog

This block is a small peripheral for an 8-bit microcontroller. One binary divider, clocked by the bus clock, drives three features. A fixed low tap advances an 8-bit free-running counter, and the counter raises an overflow flag each time it wraps. A selectable high tap produces a periodic tick that sets a real-time flag. The same tick drives a watchdog. If software does not clear the watchdog within eight ticks, the watchdog emits a reset pulse.

Software reaches the block through a two-location register port. Location 0 holds control and status: flags, enables, write-only acknowledge bits and the rate select. Location 1 holds the counter, which is read-only. A flag is cleared by writing a one to its acknowledge bit. Each interrupt request output is the AND of a flag and its enable. The register port has no data stream, so it has no valid/ready back-pressure: a write strobe takes effect at the next edge, and read data is registered.

Top module: `mft_timer`

## Requirements
- R1: After reset, location 0 reads 0x03 (slowest rate selected, flags and enables clear) and location 1 reads 0x00.
- R2: Location 0 reads as {ovf_flag, rti_flag, ovf_en, rti_en, 0, 0, rate[1:0]} from bit 7 down to bit 0. Bits 3 and 2 always read zero. Writes change only bits 5, 4, 1 and 0.
- R3: The counter advances by one every 2^CNT_TAP clocks. Writes to location 1 do not change it.
- R4: When the counter steps from 0xFF to 0x00, the overflow flag is set.
- R5: The real-time flag is set once every 2^(RTI_BASE+rate) clocks, with rate 0..3 taken from bits 1:0.
- R6: Writing 1 to bit 3 clears the overflow flag, and writing 1 to bit 2 clears the real-time flag. Writing 0 to either bit has no effect.
- R7: If a flag's set event and a write of 1 to its acknowledge bit fall in the same cycle, the flag ends up set.
- R8: irq_ovf equals ovf_flag AND bit 5, and irq_rti equals rti_flag AND bit 4.
- R9: cop_rst pulses for one clock when eight real-time ticks pass without cop_clr. A cop_clr restarts the count and suppresses a pulse in its own cycle.
- R10: rd_data takes the addressed value in the cycle after rd_en and holds it while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register select: 0 control/status, 1 counter |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq_ovf | output | 1 | Counter overflow interrupt request |
| irq_rti | output | 1 | Real-time tick interrupt request |
| cop_clr | input | 1 | Watchdog clear strobe |
| cop_rst | output | 1 | One-clock watchdog timeout pulse |

## Verification
Directed runs step through each of the four rate selects and measure the spacing between real-time flag sets, which shows whether the right divider tap was picked. Acknowledge writes are placed on ordinary cycles and also exactly on a set event, which separates "clear works" from "set wins". The watchdog is run with no clears and then with regular clears, so a missing timeout can be told apart from a spurious one. A long run of seeded random register writes, reads and clears, checked every cycle against a bench model, exposes stray field decoding, counter writability and read-hold faults.

// File: rtl/mft_pkg.sv
package mft_pkg;
  localparam int CSR_OVF    = 7;
  localparam int CSR_RTI    = 6;
  localparam int CSR_OVFE   = 5;
  localparam int CSR_RTIE   = 4;
  localparam int CSR_OVFACK = 3;
  localparam int CSR_RTIACK = 2;
  localparam int RATE_W     = 2;
  localparam int NUM_RATES  = 1 << RATE_W;

  typedef enum logic {
    SEL_CSR = 1'b0,
    SEL_CNT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mft_divider.sv
module mft_divider import mft_pkg::*; #(
  parameter int RTI_BASE = 14,
  parameter int CNT_TAP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              cnt_tick,
  output logic              rti_tick
);
  localparam int DIV_W = RTI_BASE + NUM_RATES - 1;

  logic [DIV_W-1:0]     div_q;
  logic [NUM_RATES-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // each tap fires in the last cycle of its 2^n window
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
    assign taps[g] = &div_q[RTI_BASE+g-1:0];
  end

  assign rti_tick = taps[rate];
  assign cnt_tick = &div_q[CNT_TAP-1:0];

  // R5
  slow_tap_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taps[NUM_RATES-1] |-> taps[0]);
endmodule

// File: rtl/mft_count8.sv
module mft_count8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] value,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (tick) value <= value + 1'b1;
  end

  assign wrap = tick & (&value);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(value));
endmodule

// File: rtl/mft_cop.sv
module mft_cop #(
  parameter int PERIODS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rti_tick,
  input  logic clr,
  output logic cop_rst
);
  localparam int CW = $clog2(PERIODS);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= '0;
      cop_rst <= 1'b0;
    end else if (clr) begin
      seen    <= '0;
      cop_rst <= 1'b0;
    end else if (rti_tick) begin
      if (seen == CW'(PERIODS - 1)) begin
        seen    <= '0;
        cop_rst <= 1'b1;
      end else begin
        seen    <= seen + 1'b1;
        cop_rst <= 1'b0;
      end
    end else begin
      cop_rst <= 1'b0;
    end
  end

  // R9
  cop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_rst |=> !cop_rst);
  // R9
  cop_clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !cop_rst);
endmodule

// File: rtl/mft_timer.sv
module mft_timer import mft_pkg::*; #(
  parameter int RTI_BASE    = 14,
  parameter int CNT_TAP     = 2,
  parameter int COP_PERIODS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       irq_ovf,
  output logic       irq_rti,
  input  logic       cop_clr,
  output logic       cop_rst
);
  logic              cnt_tick, rti_tick, wrap;
  logic [7:0]        cnt_val;
  logic              ovf_flag, rti_flag, ovf_en, rti_en;
  logic [RATE_W-1:0] rate;
  logic              csr_wr, ovf_ack, rti_ack;
  logic [7:0]        csr_view;
  logic              unused_wr_hi;

  mft_divider #(.RTI_BASE(RTI_BASE), .CNT_TAP(CNT_TAP)) u_div (
    .clk(clk), .rst_n(rst_n), .rate(rate),
    .cnt_tick(cnt_tick), .rti_tick(rti_tick)
  );

  mft_count8 #(.W(8)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick),
    .value(cnt_val), .wrap(wrap)
  );

  mft_cop #(.PERIODS(COP_PERIODS)) u_cop (
    .clk(clk), .rst_n(rst_n), .rti_tick(rti_tick),
    .clr(cop_clr), .cop_rst(cop_rst)
  );

  assign csr_wr       = wr_en && (reg_sel_e'(addr) == SEL_CSR);
  assign ovf_ack      = csr_wr && wr_data[CSR_OVFACK];
  assign rti_ack      = csr_wr && wr_data[CSR_RTIACK];
  assign unused_wr_hi = ^wr_data[7:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      rti_flag <= 1'b0;
      ovf_en   <= 1'b0;
      rti_en   <= 1'b0;
      rate     <= '1;
    end else begin
      ovf_flag <= wrap     | (ovf_flag & ~ovf_ack);
      rti_flag <= rti_tick | (rti_flag & ~rti_ack);
      if (csr_wr) begin
        ovf_en <= wr_data[CSR_OVFE];
        rti_en <= wr_data[CSR_RTIE];
        rate   <= wr_data[RATE_W-1:0];
      end
    end
  end

  assign csr_view = {ovf_flag, rti_flag, ovf_en, rti_en, 2'b00, rate};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= (reg_sel_e'(addr) == SEL_CNT) ? cnt_val : csr_view;
  end

  assign irq_ovf = ovf_flag & ovf_en;
  assign irq_rti = rti_flag & rti_en;

  // R7
  rti_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rti_tick |=> rti_flag);
  // R7
  ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  // R6
  rti_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_ack && !rti_tick) |=> !rti_flag);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/mft_timer_test.sv
module mft_timer_test;
  localparam int RB = 3;
  localparam int CT = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, cop_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_ovf, irq_rti, cop_rst;

  int checks = 0, fails = 0, cyc_n = 0;

  always #2 clk = ~clk;

  mft_timer #(.RTI_BASE(RB), .CNT_TAP(CT), .COP_PERIODS(8)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_ovf(irq_ovf), .irq_rti(irq_rti),
    .cop_clr(cop_clr), .cop_rst(cop_rst)
  );

  // bench model, built from the requirements
  int unsigned m_div;
  logic [7:0]  m_cnt, m_rd;
  logic        m_ovf, m_rti, m_ovfe, m_rtie, m_cop;
  logic [1:0]  m_rate;
  logic [2:0]  m_seen;

  function automatic bit f_tap(int unsigned d, int n);
    int unsigned mask = (32'd1 << n) - 1;
    return (d & mask) == mask;
  endfunction

  function automatic logic [7:0] f_csr();
    return {m_ovf, m_rti, m_ovfe, m_rtie, 2'b00, m_rate};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_rd = 0; m_ovf = 0; m_rti = 0;
      m_ovfe = 0; m_rtie = 0; m_cop = 0; m_rate = 2'b11; m_seen = 0;
    end else begin
      bit ct, rt, wr, wrp;
      ct  = f_tap(m_div, CT);
      rt  = f_tap(m_div, RB + int'(m_rate));
      wr  = wr_en && !addr;
      wrp = ct && (m_cnt == 8'hFF);
      if (rd_en) m_rd = addr ? m_cnt : f_csr();
      m_ovf = wrp | (m_ovf & !(wr && wr_data[3]));
      m_rti = rt  | (m_rti & !(wr && wr_data[2]));
      if (wr) begin
        m_ovfe = wr_data[5]; m_rtie = wr_data[4]; m_rate = wr_data[1:0];
      end
      if (cop_clr) begin m_seen = 0; m_cop = 0; end
      else if (rt) begin
        m_cop = (m_seen == 3'd7);
        m_seen = m_seen + 3'd1;
      end else m_cop = 0;
      if (ct) m_cnt = m_cnt + 8'd1;
      m_div = m_div + 1;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // advance one clock; sample at the falling edge, then release strobes
  task automatic cyc();
    @(negedge clk);
    cyc_n++;
    check("R8", "irq_ovf", int'(irq_ovf), int'(m_ovf & m_ovfe));
    check("R8", "irq_rti", int'(irq_rti), int'(m_rti & m_rtie));
    check("R9", "cop_rst", int'(cop_rst), int'(m_cop));
    check("R10", "rd_data", int'(rd_data), int'(m_rd));
    wr_en = 0; rd_en = 0; cop_clr = 0;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1; cyc();
  endtask

  task automatic rd(logic a);
    addr = a; rd_en = 1; cyc();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    while (cyc_n < 100000) @(negedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc_n, 100000);
    finish_up();
  end

  initial begin
    void'($urandom(32'd5081));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    rd(0); check("R1", "csr reset", int'(rd_data), 8'h03);
    rd(1); check("R1", "cnt reset", int'(rd_data), 8'h00);

    // R2 layout: ack bits read zero, flag bits not writable
    wr(0, 8'hFF); rd(0);
    check("R2", "ack bits zero", int'(rd_data & 8'h0C), 0);
    check("R2", "enables/rate", int'(rd_data & 8'h33), 8'h33);
    wr(0, 8'h00); rd(0);
    check("R2", "flags unwritable", int'(rd_data), int'({m_ovf, m_rti, 6'b0}));

    // R3 step rate and read-only counter
    begin
      logic [7:0] a;
      rd(1); a = rd_data;
      repeat (9) cyc();
      rd(1);
      check("R3", "cnt delta", int'(rd_data - a), 10 >> CT);
      wr(1, 8'hAA); rd(1);
      check("R3", "cnt not written", int'(rd_data == 8'hAA), 0);
    end

    // R5 period per rate select
    for (int s = 0; s < 4; s++) begin
      int t1;
      wr(0, 8'h14 | 8'(s));
      while (!irq_rti) cyc();
      wr(0, 8'h14 | 8'(s));
      while (!irq_rti) cyc();
      t1 = cyc_n;
      // R6: writing zero to the ack bit leaves the flag
      wr(0, 8'h10 | 8'(s));
      check("R6", "ack0 keeps rti", int'(irq_rti), 1);
      wr(0, 8'h14 | 8'(s));
      while (!irq_rti) cyc();
      check("R5", "rti period", cyc_n - t1, 1 << (RB + s));
      wr(0, 8'h14 | 8'(s));
      check("R6", "ack1 clears rti", int'(irq_rti), 0);
    end

    // R7 ack on the exact set cycle
    wr(0, 8'h10);
    while (!f_tap(m_div, RB)) cyc();
    wr(0, 8'h14);
    check("R7", "set wins", int'(irq_rti), 1);

    // R4 overflow
    wr(0, 8'h28);
    repeat (600) cyc();
    check("R4", "ovf flag", int'(irq_ovf), 1);
    wr(0, 8'h28);
    check("R6", "ovf ack", int'(irq_ovf), 0);

    // R9 watchdog timeout and clear
    begin
      int pulses = 0;
      wr(0, 8'h00);
      cop_clr = 1; cyc();
      repeat (68) begin cyc(); pulses += int'(cop_rst); end
      check("R9", "timeout pulses", pulses, 1);
      pulses = 0;
      for (int k = 0; k < 300; k++) begin
        if (k % 40 == 0) cop_clr = 1;
        cyc(); pulses += int'(cop_rst);
      end
      check("R9", "cleared pulses", pulses, 0);
    end

    // random mix checked every cycle against the model (R10, R8, R9)
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      if (r < 10) begin addr = 0; wr_data = 8'($urandom); wr_en = 1; end
      else if (r < 14) begin addr = 1; wr_data = 8'($urandom); wr_en = 1; end
      else if (r < 34) begin addr = 1'($urandom); rd_en = 1; end
      if ($urandom % 100 < 4) cop_clr = 1;
      cyc();
    end

    finish_up();
  end
endmodule